// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register Front-End

This block is the host-facing register set of one bus-master disk DMA channel. Software programs a descriptor-table pointer, writes a command register to launch or request a stop, and reads a status register for the active, error and interrupt flags. The block turns a launch into a single-cycle start pulse plus a direction level for the descriptor-walking engine. It then waits for that engine's completion report and updates the flags.

A stop request never aborts a transfer already running. The command value is stored, but the channel stays active until the engine reports completion. Pointer writes of byte, halfword or word width are merged into the addressed byte lanes, and the two low bits are always forced to zero. Every pointer write also reloads the working table pointer.

The block also holds the per-transfer working state: the working table pointer, the current descriptor's buffer address, its remaining length and an end-of-table flag. The engine updates this state through a descriptor-fetch port and a bytes-moved port.

Top module: `bmdma_regs`

## Requirements
- R1: The command register is at offset 0 and keeps only bit 0 (start) and bit 3 (direction) of `reg_wdata[7:0]`. Reads at offset 0 return zero in every other bit. `eng_dir` follows the stored bit 3.
- R2: A command write with bit 0 set while the channel is inactive sets the active flag (status bit 0) and raises `eng_start` for exactly the one cycle after the write edge.
- R3: A command write with bit 0 clear does not clear the active flag. The channel stays active until `eng_done` arrives, and the written command value is still stored.
- R4: A command write with bit 0 set while the channel is active produces no `eng_start` pulse.
- R5: The pointer sits at offsets 4 to 7. `reg_addr[1:0]` selects the starting byte lane. `reg_size` selects the width: 0 is byte, 1 is halfword, 2 or 3 is word. A word write always uses lane 0. Data comes from the low bits of `reg_wdata`. Only the addressed lanes that lie inside the register change.
- R6: Bits 1:0 of the pointer read as zero after every write.
- R7: Every pointer write, of any width, copies the new merged pointer into `cur_ptr`.
- R8: A pointer read returns the pointer shifted right by 8 times the lane and masked to the access width. A word read returns the whole pointer.
- R9: `eng_done` while active clears the active flag and sets the interrupt flag (status bit 2). If `eng_err` is also high, the error flag (status bit 1) is set as well. `eng_done` while inactive changes nothing.
- R10: A status write at offset 2 clears error and interrupt where `reg_wdata` bits 1 and 2 are 1. A flag being set in the same cycle takes priority over the clear.
- R11: `desc_fetch` loads the buffer address, length and last flag and advances `cur_ptr` by 8. A pointer write in the same cycle takes priority for `cur_ptr`.
- R12: `xfer_valid` without `desc_fetch` adds `xfer_bytes` to `cur_buf_addr` and subtracts it from `cur_len`, stopping at 0. `mid_desc` is high exactly when `cur_len` is nonzero.
- R13: After reset, command, status, pointer and all working state read zero, and `eng_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| reg_wdata | input | 32 | Write data, low-aligned |
| reg_rdata | output | 32 | Read data for reg_addr/reg_size (combinational) |
| eng_start | output | 1 | One-cycle launch pulse to engine |
| eng_dir | output | 1 | Transfer direction from command bit 3 |
| eng_done | input | 1 | Engine completion report |
| eng_err | input | 1 | Engine error qualifier for eng_done |
| desc_fetch | input | 1 | Engine loaded a new descriptor |
| desc_addr | input | 32 | Fetched buffer address |
| desc_len | input | LEN_W | Fetched byte count |
| desc_last | input | 1 | Fetched descriptor is end of table |
| xfer_valid | input | 1 | Engine moved bytes this cycle |
| xfer_bytes | input | LEN_W | Bytes moved |
| cur_ptr | output | 32 | Working table pointer |
| cur_buf_addr | output | 32 | Current buffer address |
| cur_len | output | LEN_W | Remaining length of current descriptor |
| cur_last | output | 1 | Current descriptor ends the table |
| mid_desc | output | 1 | Remaining length nonzero |

## Verification
If the active flag is wrong, it shows within one cycle: a second start pulse, a missing pulse, or a stop that ends the transfer early, all visible on `eng_start` and on a status read. A wrong lane merge or alignment shows up on the next pointer readback and on `cur_ptr` one cycle after the write edge. Errors in the working state show the cycle after a fetch or move, in `cur_len`, `cur_buf_addr` and `mid_desc`. The saturation at zero and the priority of a pointer write over a fetch are driven on purpose.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int PTR_W = 32;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  function automatic logic [PTR_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] lane_shift(input logic [1:0] lane, input logic [1:0] sz);
    lane_shift = (sz[1]) ? 5'd0 : {lane, 3'b000};
  endfunction

  function automatic logic [PTR_W-1:0] lane_merge(input logic [PTR_W-1:0] old,
                                                  input logic [PTR_W-1:0] wd,
                                                  input logic [1:0] lane,
                                                  input logic [1:0] sz);
    logic [PTR_W-1:0] m, v;
    m = width_mask(sz) << lane_shift(lane, sz);
    v = (wd & width_mask(sz)) << lane_shift(lane, sz);
    lane_merge = ((old & ~m) | (v & m)) & ~32'h3;
  endfunction

  function automatic logic [PTR_W-1:0] lane_read(input logic [PTR_W-1:0] val,
                                                 input logic [1:0] lane,
                                                 input logic [1:0] sz);
    lane_read = (val >> lane_shift(lane, sz)) & width_mask(sz);
  endfunction
endpackage

// File: rtl/bmdma_ptr.sv
module bmdma_ptr
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       lane,
  input  logic [1:0]       sz,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr_next,
  output logic [PTR_W-1:0] ptr_q
);
  assign ptr_next = lane_merge(ptr_q, wdata, lane, sz);

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_next;
  end

  // R6: table pointer stays word aligned
  p_align_r6: assert property (@(posedge clk) disable iff (!rst_n) ptr_q[1:0] == 2'b00);
  // R5: no write, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(ptr_q));
endmodule

// File: rtl/bmdma_ctl.sv
module bmdma_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       sts_we,
  input  logic [7:0] wbyte,
  input  logic       eng_done,
  input  logic       eng_err,
  output logic [7:0] cmd_rd,
  output logic [7:0] sts_rd,
  output logic       eng_start,
  output logic       eng_dir
);
  logic run_q, dir_q, active_q, err_q, irq_q;
  logic launch, done_ev;

  assign launch  = cmd_we & wbyte[0] & ~active_q;
  assign done_ev = eng_done & active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; dir_q <= 1'b0; active_q <= 1'b0;
      err_q <= 1'b0; irq_q <= 1'b0; eng_start <= 1'b0;
    end else begin
      eng_start <= launch;
      if (cmd_we) begin
        run_q <= wbyte[0];
        dir_q <= wbyte[3];
      end
      if (done_ev)     active_q <= 1'b0;
      else if (launch) active_q <= 1'b1;
      if (done_ev)                   irq_q <= 1'b1;
      else if (sts_we && wbyte[2])   irq_q <= 1'b0;
      if (done_ev && eng_err)        err_q <= 1'b1;
      else if (sts_we && wbyte[1])   err_q <= 1'b0;
    end
  end

  assign eng_dir = dir_q;
  assign cmd_rd  = {4'b0, dir_q, 2'b00, run_q};
  assign sts_rd  = {5'b0, irq_q, err_q, active_q};

  // R2: start pulse is one cycle long and comes with active
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start);
  p_act_r2: assert property (@(posedge clk) disable iff (!rst_n) eng_start |-> active_q);
  // R4: no relaunch while active
  p_norelaunch_r4: assert property (@(posedge clk) disable iff (!rst_n) active_q |=> !eng_start);
  // R3: only completion ends activity
  p_noabort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !eng_done) |=> active_q);
  // R9: completion clears active and raises interrupt
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && eng_done) |=> (!active_q && irq_q));
endmodule

// File: rtl/bmdma_track.sv
module bmdma_track #(
  parameter int AW     = 32,
  parameter int LEN_W  = 16,
  parameter int STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_load,
  input  logic [AW-1:0]    ptr_val,
  input  logic             fetch,
  input  logic [AW-1:0]    f_addr,
  input  logic [LEN_W-1:0] f_len,
  input  logic             f_last,
  input  logic             xfer,
  input  logic [LEN_W-1:0] xbytes,
  output logic [AW-1:0]    cur_ptr,
  output logic [AW-1:0]    buf_addr,
  output logic [LEN_W-1:0] len,
  output logic             last,
  output logic             mid
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  function automatic logic [LEN_W-1:0] sat_sub(input logic [LEN_W-1:0] a, input logic [LEN_W-1:0] b);
    sat_sub = (b >= a) ? '0 : a - b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ptr <= '0; buf_addr <= '0; len <= '0; last <= 1'b0;
    end else begin
      if (ptr_load)   cur_ptr <= ptr_val;
      else if (fetch) cur_ptr <= cur_ptr + STEP;
      if (fetch) begin
        buf_addr <= f_addr; len <= f_len; last <= f_last;
      end else if (xfer) begin
        buf_addr <= buf_addr + AW'(xbytes);
        len      <= sat_sub(len, xbytes);
      end
    end
  end

  assign mid = |len;

  // R7: pointer write reloads the working pointer
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> cur_ptr == $past(ptr_val));
  // R11: fetch advances by one descriptor
  p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !ptr_load) |=> cur_ptr == $past(cur_ptr) + STEP);
  // R12: remaining length bottoms out at zero
  p_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !fetch && xbytes >= len) |=> !mid);
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [1:0]       reg_size,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             eng_start,
  output logic             eng_dir,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic             desc_fetch,
  input  logic [31:0]      desc_addr,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_last,
  input  logic             xfer_valid,
  input  logic [LEN_W-1:0] xfer_bytes,
  output logic [31:0]      cur_ptr,
  output logic [31:0]      cur_buf_addr,
  output logic [LEN_W-1:0] cur_len,
  output logic             cur_last,
  output logic             mid_desc
);
  localparam logic [2:0] OFS_CMD = 3'd0;
  localparam logic [2:0] OFS_STS = 3'd2;

  logic ptr_we, cmd_we, sts_we;
  logic [31:0] ptr_q, ptr_next;
  logic [7:0] cmd_rd, sts_rd;

  assign ptr_we = reg_wr & reg_addr[2];
  assign cmd_we = reg_wr & (reg_addr == OFS_CMD);
  assign sts_we = reg_wr & (reg_addr == OFS_STS);

  bmdma_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_we), .lane(reg_addr[1:0]), .sz(reg_size),
    .wdata(reg_wdata), .ptr_next(ptr_next), .ptr_q(ptr_q)
  );

  bmdma_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .sts_we(sts_we), .wbyte(reg_wdata[7:0]),
    .eng_done(eng_done), .eng_err(eng_err), .cmd_rd(cmd_rd), .sts_rd(sts_rd),
    .eng_start(eng_start), .eng_dir(eng_dir)
  );

  bmdma_track #(.AW(32), .LEN_W(LEN_W), .STRIDE(STRIDE)) u_trk (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_we), .ptr_val(ptr_next),
    .fetch(desc_fetch), .f_addr(desc_addr), .f_len(desc_len), .f_last(desc_last),
    .xfer(xfer_valid), .xbytes(xfer_bytes), .cur_ptr(cur_ptr), .buf_addr(cur_buf_addr),
    .len(cur_len), .last(cur_last), .mid(mid_desc)
  );

  always_comb begin
    if (reg_addr[2])               reg_rdata = lane_read(ptr_q, reg_addr[1:0], reg_size);
    else if (reg_addr == OFS_CMD)  reg_rdata = {24'b0, cmd_rd};
    else if (reg_addr == OFS_STS)  reg_rdata = {24'b0, sts_rd};
    else                           reg_rdata = '0;
  end

  // R1: only start and direction ever read back from the command register
  p_cmdbits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_CMD) |-> (reg_rdata & ~32'h9) == 32'h0);
endmodule

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;
  localparam int LEN_W = 16;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [1:0] reg_size = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic eng_start, eng_dir, eng_done = 0, eng_err = 0;
  logic desc_fetch = 0, desc_last = 0, xfer_valid = 0;
  logic [31:0] desc_addr = 0; logic [LEN_W-1:0] desc_len = 0, xfer_bytes = 0;
  logic [31:0] cur_ptr, cur_buf_addr; logic [LEN_W-1:0] cur_len; logic cur_last, mid_desc;

  int errors = 0, checks = 0;
  logic [31:0] m_ptr, m_cur, m_baddr; logic [LEN_W-1:0] m_len;
  logic m_last, m_act, m_err, m_irq, m_start, m_run, m_dir;

  always #5 clk = ~clk;

  bmdma_regs #(.LEN_W(LEN_W), .STRIDE(8)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [31:0] wd,
                                            input int lane, input int sz);
    logic [7:0] b [4];
    int n, st;
    n  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    st = (sz >= 2) ? 0 : lane;
    for (int i = 0; i < 4; i++) b[i] = old[8*i +: 8];
    for (int k = 0; k < n; k++) if (st + k < 4) b[st+k] = wd[8*k +: 8];
    exp_merge = {b[3], b[2], b[1], b[0] & 8'hFC};
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] v, input int lane, input int sz);
    logic [31:0] r = 0;
    if (sz >= 2) return v;
    for (int k = 0; k < (sz == 0 ? 1 : 2); k++) if (lane + k < 4) r[8*k +: 8] = v[8*(lane+k) +: 8];
    return r;
  endfunction

  task automatic model_reset();
    m_ptr = 0; m_cur = 0; m_baddr = 0; m_len = 0; m_last = 0;
    m_act = 0; m_err = 0; m_irq = 0; m_start = 0; m_run = 0; m_dir = 0;
  endtask

  task automatic tick();
    logic launch, done_ev;
    @(posedge clk);
    launch = 0;
    done_ev = eng_done && m_act;
    if (reg_wr && reg_addr == 3'd0) begin
      launch = reg_wdata[0] && !m_act;
      m_run = reg_wdata[0]; m_dir = reg_wdata[3];
    end
    if (done_ev) m_irq = 1; else if (reg_wr && reg_addr == 3'd2 && reg_wdata[2]) m_irq = 0;
    if (done_ev && eng_err) m_err = 1; else if (reg_wr && reg_addr == 3'd2 && reg_wdata[1]) m_err = 0;
    if (done_ev) m_act = 0; else if (launch) m_act = 1;
    m_start = launch;
    if (reg_wr && reg_addr[2]) begin
      m_ptr = exp_merge(m_ptr, reg_wdata, int'(reg_addr[1:0]), int'(reg_size));
      m_cur = m_ptr;
    end else if (desc_fetch) m_cur = m_cur + 8;
    if (desc_fetch) begin
      m_baddr = desc_addr; m_len = desc_len; m_last = desc_last;
    end else if (xfer_valid) begin
      m_baddr = m_baddr + 32'(xfer_bytes);
      m_len = (xfer_bytes >= m_len) ? '0 : m_len - xfer_bytes;
    end
    @(negedge clk);
    reg_wr = 0; eng_done = 0; eng_err = 0; desc_fetch = 0; xfer_valid = 0;
    chk("R2 eng_start", {31'b0, eng_start}, {31'b0, m_start});
    chk("R1 eng_dir", {31'b0, eng_dir}, {31'b0, m_dir});
    chk("R7 cur_ptr", cur_ptr, m_cur);
    chk("R11 cur_buf_addr", cur_buf_addr, m_baddr);
    chk("R12 cur_len", 32'(cur_len), 32'(m_len));
    chk("R11 cur_last", {31'b0, cur_last}, {31'b0, m_last});
    chk("R12 mid_desc", {31'b0, mid_desc}, {31'b0, m_len != 0});
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [1:0] s, input logic [31:0] exp);
    reg_addr = a; reg_size = s; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_size = s; reg_wdata = d; tick();
  endtask

  task automatic check_regs();
    rd("R9 status", 3'd2, 2'd0, {29'b0, m_irq, m_err, m_act});
    rd("R1 command", 3'd0, 2'd0, {28'b0, m_dir, 2'b0, m_run});
    rd("R6 pointer word", 3'd4, 2'd2, m_ptr);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    rd("R13 status", 3'd2, 2'd0, 32'h0);
    rd("R13 command", 3'd0, 2'd0, 32'h0);
    rd("R13 pointer", 3'd4, 2'd2, 32'h0);
    chk("R13 eng_start", {31'b0, eng_start}, 32'h0);
    chk("R13 cur_len", 32'(cur_len), 32'h0);
    // R1 junk bits dropped; R2 launch
    wr(3'd0, 2'd0, 32'hFF); check_regs();
    chk("R2 pulse high", {31'b0, eng_start}, 32'h1);
    tick(); chk("R2 pulse ends", {31'b0, eng_start}, 32'h0);
    // R4 start while active
    wr(3'd0, 2'd0, 32'h01); chk("R4 no relaunch", {31'b0, eng_start}, 32'h0);
    // R3 stop does not abort
    wr(3'd0, 2'd0, 32'h08); check_regs();
    chk("R3 still active", {31'b0, m_act}, 32'h1);
    tick(); check_regs();
    // R9 done with error
    eng_done = 1; eng_err = 1; tick(); check_regs();
    rd("R9 flags", 3'd2, 2'd0, 32'h6);
    // R9 done while inactive ignored; R10 W1C
    wr(3'd2, 2'd0, 32'h4); rd("R10 irq cleared", 3'd2, 2'd0, 32'h2);
    eng_done = 1; tick(); rd("R9 idle done ignored", 3'd2, 2'd0, 32'h2);
    wr(3'd2, 2'd0, 32'h2); rd("R10 err cleared", 3'd2, 2'd0, 32'h0);
    // R5/R6/R8 pointer lanes
    wr(3'd4, 2'd2, 32'h1234_5677); rd("R6 word align", 3'd4, 2'd2, 32'h1234_5674);
    wr(3'd5, 2'd0, 32'hAB);        rd("R5 byte lane1", 3'd4, 2'd2, 32'h1234_AB74);
    wr(3'd7, 2'd1, 32'hCDEF);      rd("R5 half lane3", 3'd4, 2'd2, 32'hEF34_AB74);
    wr(3'd4, 2'd0, 32'hFF);        rd("R6 byte lane0", 3'd4, 2'd2, 32'hEF34_ABFC);
    rd("R8 half lane1", 3'd5, 2'd1, 32'h0000_34AB);
    rd("R8 byte lane3", 3'd7, 2'd0, 32'h0000_00EF);
    chk("R7 reload", cur_ptr, 32'hEF34_ABFC);
    // R11/R12 fetch, move, saturate, priority
    desc_fetch = 1; desc_addr = 32'h1000; desc_len = 16'd100; desc_last = 1; tick();
    xfer_valid = 1; xfer_bytes = 16'd60; tick();
    xfer_valid = 1; xfer_bytes = 16'd60; tick();
    chk("R12 saturated", 32'(cur_len), 32'h0);
    desc_fetch = 1; desc_len = 16'd4; reg_wr = 1; reg_addr = 3'd4; reg_size = 2'd2;
    reg_wdata = 32'h8000; tick();
    chk("R11 write beats fetch", cur_ptr, 32'h8000);
    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 7;
      case (op)
        0: begin reg_wr = 1; reg_addr = 3'd0; reg_wdata = $urandom; end
        1: begin reg_wr = 1; reg_addr = 3'(4 + $urandom % 4); reg_size = 2'($urandom); reg_wdata = $urandom; end
        2: begin reg_wr = 1; reg_addr = 3'd2; reg_wdata = $urandom; end
        3: begin eng_done = 1; eng_err = 1'($urandom); end
        4: begin desc_fetch = 1; desc_addr = $urandom; desc_len = LEN_W'($urandom % 300); desc_last = 1'($urandom); end
        5: begin xfer_valid = 1; xfer_bytes = LEN_W'($urandom % 128); end
        default: begin reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'h1; eng_done = 1'($urandom); end
      endcase
      if ($urandom % 4 == 0) begin xfer_valid = 1; xfer_bytes = LEN_W'($urandom % 64); end
      tick();
      check_regs();
      begin
        int ln = $urandom % 4; int sz = $urandom % 3;
        rd("R8 random read", 3'(4 + ln), 2'(sz), exp_read(m_ptr, ln, sz));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule